// File: doc/BRIEF.md
# GPIO Controller with Routed Interrupts

This block is a general-purpose I/O controller for up to 32 pins, accessed through a simple 32-bit register bus with single-cycle writes and combinational reads. Software uses per-pin registers to set each pin's direction and drive value, and reads back each pin's level after synchronization. An optional per-pin bypass shortens the synchronizer to one flop.

Each pin can raise an interrupt. A polarity bit and an edge bit select the condition: low level, high level, falling edge or rising edge. An interrupt mask gates each pin. A per-pin route field sends the pin's event to one of `NIRQ` shared interrupt outputs, or to none. Several pins may share one output, and the output is the OR of their events. Level events hold an output for as long as the condition lasts. Edge events produce a single-cycle pulse.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` is all zero and `irq_out` is all zero.
- R2: The output-value register (word offset 0x04) drives `pin_out` and the direction register (0x08) drives `pin_oe`, where bit n = 1 makes pin n an output. Both read back as written.
- R3: The input register (0x00) returns bit n of `pin_in` after a two-flop synchronizer. A change made between clock edges is visible after the second rising edge and not after the first.
- R4: When bit n of the bypass register (0x18) is 1, pin n skips the second flop, so a change on that pin is visible after one rising edge. Pins that are not bypassed keep the two-edge delay.
- R5: In level mode (edge bit 0 in register 0x14), polarity bit 1 (register 0x10) asserts the routed output while the sampled pin is high, and polarity bit 0 asserts it while the pin is low. The output stays asserted for as long as the condition lasts.
- R6: In edge mode (edge bit 1), polarity 1 fires on a rising sample and polarity 0 fires on a falling sample. Each such edge gives a one-cycle pulse, and an edge of the other direction gives nothing.
- R7: A pin whose bit in the mask register (0x0C) is 0 never asserts any interrupt output.
- R8: Route fields are 8 bits, four to a word, starting at 0x20. Pin p lives in word 0x20+4*(p/4), at bits [31-8*(p%4) -: 8], so pin 0 is in bits [31:24] of 0x20. Field bit 7 enables the route and bits [4:0] pick the output index. A disabled field, or an index of `NIRQ` or above, routes the pin nowhere. Field bits 6:5 read as zero.
- R9: Several pins routed to the same output combine by OR.
- R10: Addresses outside the register map read zero, and writes to them change no register. This includes 0x1C, anything past the last route word, and any address not aligned to a word.
- R11: An interrupt output changes one rising edge after the synchronized sample shows the condition. With a normal two-flop pin, this is three rising edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not selected) |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Pin drive values |
| pin_oe | output | NPINS | Pin output enables |
| irq_out | output | NIRQ | Routed interrupt outputs |

## Verification
The bench samples a pin one edge before and one edge after each expected change. A synchronizer with a stage missing or added, or an interrupt output that is not registered, shows up as a wrong value at one of those two samples. Edge-mode tests hold the pin steady after the pulse and also drive an edge of the opposite direction. A detector that compares against a stale sample, or that ignores polarity, shows up as a stretched pulse or a spurious one. The route tests write pin 0 into the top byte and use out-of-range and disabled fields, which exposes a reversed byte lane or a missing enable check. Writes to holes and to unaligned addresses catch a decoder that looks only at the upper address bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 5;

  localparam logic [5:0] W_DATA = 6'd0;
  localparam logic [5:0] W_OUT  = 6'd1;
  localparam logic [5:0] W_DIR  = 6'd2;
  localparam logic [5:0] W_MASK = 6'd3;
  localparam logic [5:0] W_POL  = 6'd4;
  localparam logic [5:0] W_EDGE = 6'd5;
  localparam logic [5:0] W_BYP  = 6'd6;
  localparam logic [5:0] W_MAP0 = 6'd8;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } route_t;

  // Event condition from polarity/edge select and current/previous sample
  function automatic logic pin_event(input logic pol, input logic edg,
                                     input logic cur, input logic prev);
    if (edg) return pol ? (cur & ~prev) : (~cur & prev);
    return pol ? cur : ~cur;
  endfunction

  function automatic logic [7:0] pack_route(input route_t r);
    return {r.en, 2'b00, r.idx};
  endfunction

  function automatic route_t unpack_route(input logic [7:0] b);
    route_t r;
    r.en  = b[7];
    r.idx = b[IDX_W-1:0];
    return r;
  endfunction

  // Lowest bit of pin p's byte lane inside its route word
  function automatic int lane_lsb(input int pin);
    return 24 - 8 * (pin % 4);
  endfunction
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] bypass,
  output logic [NPINS-1:0] samp,
  output logic [NPINS-1:0] prev
);
  logic [NPINS-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= pin_in;
      s2   <= s1;
      prev <= samp;
    end
  end

  always_comb samp = (bypass & s1) | (~bypass & s2);
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [REG_W-1:0]        bus_wdata,
  output logic [REG_W-1:0]        bus_rdata,
  input  logic [NPINS-1:0]        samp,
  output logic [NPINS-1:0]        out_q,
  output logic [NPINS-1:0]        dir_q,
  output logic [NPINS-1:0]        mask_q,
  output logic [NPINS-1:0]        pol_q,
  output logic [NPINS-1:0]        edge_q,
  output logic [NPINS-1:0]        byp_q,
  output route_t [NPINS-1:0]      routes
);
  logic [5:0] word;
  logic       aligned, wr_en;

  assign word    = bus_addr[7:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_sel & bus_wr & aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      byp_q  <= '0;
    end else if (wr_en) begin
      case (word)
        W_OUT:  out_q  <= bus_wdata[NPINS-1:0];
        W_DIR:  dir_q  <= bus_wdata[NPINS-1:0];
        W_MASK: mask_q <= bus_wdata[NPINS-1:0];
        W_POL:  pol_q  <= bus_wdata[NPINS-1:0];
        W_EDGE: edge_q <= bus_wdata[NPINS-1:0];
        W_BYP:  byp_q  <= bus_wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_route
    localparam logic [5:0] MY_WORD = 6'(W_MAP0 + p / 4);
    localparam int         LSB     = lane_lsb(p);
    always_ff @(posedge clk) begin
      if (!rst_n) routes[p] <= '0;
      else if (wr_en && word == MY_WORD)
        routes[p] <= unpack_route(bus_wdata[LSB +: 8]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && aligned) begin
      case (word)
        W_DATA: bus_rdata[NPINS-1:0] = samp;
        W_OUT:  bus_rdata[NPINS-1:0] = out_q;
        W_DIR:  bus_rdata[NPINS-1:0] = dir_q;
        W_MASK: bus_rdata[NPINS-1:0] = mask_q;
        W_POL:  bus_rdata[NPINS-1:0] = pol_q;
        W_EDGE: bus_rdata[NPINS-1:0] = edge_q;
        W_BYP:  bus_rdata[NPINS-1:0] = byp_q;
        default: begin
          for (int p = 0; p < NPINS; p++)
            if (word == 6'(W_MAP0 + p / 4))
              bus_rdata[lane_lsb(p) +: 8] = pack_route(routes[p]);
        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NIRQ  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   samp,
  input  logic [NPINS-1:0]   prev,
  input  logic [NPINS-1:0]   mask_q,
  input  logic [NPINS-1:0]   pol_q,
  input  logic [NPINS-1:0]   edge_q,
  input  route_t [NPINS-1:0] routes,
  output logic [NIRQ-1:0]    irq_out
);
  logic [NPINS-1:0] hit;
  logic [NIRQ-1:0]  irq_nxt;

  for (genvar p = 0; p < NPINS; p++) begin : g_hit
    assign hit[p] = mask_q[p] & routes[p].en &
                    pin_event(pol_q[p], edge_q[p], samp[p], prev[p]);
  end

  for (genvar j = 0; j < NIRQ; j++) begin : g_out
    logic [NPINS-1:0] sel;
    for (genvar p = 0; p < NPINS; p++) begin : g_sel
      assign sel[p] = (routes[p].idx == IDX_W'(j));
    end
    assign irq_nxt[j] = |(hit & sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_nxt;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NIRQ  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NIRQ-1:0]  irq_out
);
  logic [NPINS-1:0]   samp, prev;
  logic [NPINS-1:0]   out_q, dir_q, mask_q, pol_q, edge_q, byp_q;
  route_t [NPINS-1:0] routes;

  gpio_sync_edge #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bypass(byp_q),
    .samp(samp), .prev(prev)
  );

  gpio_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .samp(samp), .out_q(out_q), .dir_q(dir_q), .mask_q(mask_q),
    .pol_q(pol_q), .edge_q(edge_q), .byp_q(byp_q), .routes(routes)
  );

  gpio_irq_route #(.NPINS(NPINS), .NIRQ(NIRQ)) u_route (
    .clk(clk), .rst_n(rst_n), .samp(samp), .prev(prev), .mask_q(mask_q),
    .pol_q(pol_q), .edge_q(edge_q), .routes(routes), .irq_out(irq_out)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter int NPINS = 32,
  parameter int NIRQ  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_oe,
  input logic [NIRQ-1:0]  irq_out,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] byp_q,
  input logic [NPINS-1:0] samp
);
  localparam int MAPW = (NPINS + 3) / 4;
  localparam int MAP_END = 32 + 4 * MAPW;

  logic       was_rst;
  logic [1:0] cyc;

  always_ff @(posedge clk) was_rst <= !rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  function automatic logic in_map(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 1'b0;
    return (a <= 8'h18) || (a >= 8'h20 && int'(a) < MAP_END);
  endfunction

  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    was_rst |-> (irq_out == '0 && pin_oe == '0));

  // R2: a direction write shows on pin_oe one edge later
  a_r2_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h08) |=> pin_oe == $past(bus_wdata[NPINS-1:0]));

  // R3: non-bypassed pins are delayed by two edges
  a_r3_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> ((samp & ~byp_q) == ($past(pin_in, 2) & ~byp_q)));

  // R4: bypassed pins are delayed by one edge
  a_r4_bypass_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1) |-> ((samp & byp_q) == ($past(pin_in) & byp_q)));

  // R7: fully masked controller produces no interrupt
  a_r7_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && $past(mask_q) == '0) |-> irq_out == '0);

  // R10: holes in the map read zero
  a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !in_map(bus_addr)) |-> bus_rdata == '0);
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NPINS(NPINS), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_in(pin_in), .pin_oe(pin_oe), .irq_out(irq_out),
  .mask_q(mask_q), .byp_q(byp_q), .samp(samp)
);

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 32;
  localparam int NIRQ  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic [NIRQ-1:0]  irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  gpio_irq_router #(.NPINS(NPINS), .NIRQ(NIRQ)) u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cfg();
    bwr(8'h0C, 0); bwr(8'h10, 0); bwr(8'h14, 0); bwr(8'h18, 0);
    for (int w = 0; w < 8; w++) bwr(8'(8'h20 + 4 * w), 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int w = 0; w < 12; w++) begin
      brd(8'(4 * w), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 oe reset", pin_oe, 0);
    chk("R1 irq reset", 32'(irq_out), 0);
  endtask

  task automatic t_dir_out();
    logic [31:0] d;
    bwr(8'h04, 32'hA5A5_0F0F);
    bwr(8'h08, 32'hFFFF_0000);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    brd(8'h04, d); chk("R2 out readback", d, 32'hA5A5_0F0F);
    brd(8'h08, d); chk("R2 dir readback", d, 32'hFFFF_0000);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    pin_in = 32'h1234_5678;
    edges(1); brd(8'h00, d); chk("R3 not after one edge", d, 0);
    edges(1); brd(8'h00, d); chk("R3 after two edges", d, 32'h1234_5678);
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    bwr(8'h18, 32'h0000_00FF);
    pin_in = 32'hEDCB_A9A5;
    edges(1); brd(8'h00, d); chk("R4 bypassed byte after one edge", d, 32'h1234_56A5);
    edges(1); brd(8'h00, d); chk("R4 rest after two edges", d, 32'hEDCB_A9A5);
    bwr(8'h18, 0);
    pin_in = 0;
    edges(4);
  endtask

  task automatic t_level();
    bwr(8'h20, 32'h0000_0081);  // pin3 -> output 1
    bwr(8'h10, 32'h8);
    bwr(8'h14, 0);
    bwr(8'h0C, 32'h8);
    edges(3); chk("R5 level high idle", 32'(irq_out), 0);
    pin_in[3] = 1'b1;
    edges(2); chk("R11 not yet at two edges", 32'(irq_out), 0);
    edges(1); chk("R11 asserted at three edges", 32'(irq_out), 32'h2);
    edges(5); chk("R5 held while high", 32'(irq_out), 32'h2);
    pin_in[3] = 1'b0;
    edges(2); chk("R11 held until third edge", 32'(irq_out), 32'h2);
    edges(1); chk("R5 released", 32'(irq_out), 0);
    bwr(8'h10, 0);
    edges(1); chk("R5 level low asserts", 32'(irq_out), 32'h2);
    pin_in[3] = 1'b1;
    edges(3); chk("R5 level low released", 32'(irq_out), 0);
    clear_cfg();
  endtask

  task automatic t_edge();
    bwr(8'h24, 32'h0082_0000);  // pin5 -> output 2
    bwr(8'h10, 32'h20);
    bwr(8'h14, 32'h20);
    bwr(8'h0C, 32'h20);
    edges(2);
    pin_in[5] = 1'b1;
    edges(2); chk("R6 rise not yet", 32'(irq_out), 0);
    edges(1); chk("R6 rise pulse", 32'(irq_out), 32'h4);
    edges(1); chk("R6 pulse one cycle", 32'(irq_out), 0);
    edges(4); chk("R6 no repeat while high", 32'(irq_out), 0);
    bwr(8'h10, 0);
    pin_in[5] = 1'b0;
    edges(3); chk("R6 fall pulse", 32'(irq_out), 32'h4);
    edges(1); chk("R6 fall pulse ends", 32'(irq_out), 0);
    pin_in[5] = 1'b1;
    edges(3); chk("R6 rise ignored in fall mode", 32'(irq_out), 0);
    edges(1); chk("R6 rise ignored later", 32'(irq_out), 0);
    pin_in[5] = 1'b0;
    clear_cfg();
  endtask

  task automatic t_mask();
    pin_in[3] = 1'b1;
    bwr(8'h20, 32'h0000_0081);
    bwr(8'h10, 32'h8);
    edges(4); chk("R7 masked pin quiet", 32'(irq_out), 0);
    bwr(8'h0C, 32'h8);
    edges(1); chk("R7 unmasked fires", 32'(irq_out), 32'h2);
    bwr(8'h0C, 0);
    edges(1); chk("R7 remasked quiet", 32'(irq_out), 0);
    clear_cfg();
  endtask

  task automatic t_map();
    logic [31:0] d;
    bwr(8'h20, 32'hFFFF_FFFF);
    brd(8'h20, d); chk("R8 field readback", d, 32'h9F9F_9F9F);
    bwr(8'h10, 32'h8);
    bwr(8'h0C, 32'h8);
    edges(3); chk("R8 index out of range routes nowhere", 32'(irq_out), 0);
    bwr(8'h20, 32'h0000_0001);
    edges(3); chk("R8 disabled field routes nowhere", 32'(irq_out), 0);
    bwr(8'h20, 32'h0000_0083);
    edges(1); chk("R8 pin3 to output 3", 32'(irq_out), 32'h8);
    bwr(8'h0C, 0);
    pin_in[3] = 1'b0;
    pin_in[0] = 1'b1;
    bwr(8'h20, 32'h8000_0000);
    bwr(8'h10, 32'h1);
    bwr(8'h0C, 32'h1);
    edges(1); chk("R8 pin0 in top byte", 32'(irq_out), 32'h1);
    pin_in[0] = 1'b0;
    clear_cfg();
  endtask

  task automatic t_share();
    bwr(8'h20, 32'h8080_0000);  // pins 0,1 -> output 0
    bwr(8'h10, 32'h3);
    bwr(8'h0C, 32'h3);
    edges(3); chk("R9 idle", 32'(irq_out), 0);
    pin_in[0] = 1'b1;
    edges(3); chk("R9 pin0 on shared", 32'(irq_out), 32'h1);
    pin_in[0] = 1'b0; pin_in[1] = 1'b1;
    edges(3); chk("R9 pin1 on shared", 32'(irq_out), 32'h1);
    pin_in[1] = 1'b0;
    edges(3); chk("R9 both low", 32'(irq_out), 0);
    clear_cfg();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bwr(8'h1C, 32'hFFFF_FFFF);
    bwr(8'h40, 32'hFFFF_FFFF);
    bwr(8'h05, 32'hFFFF_FFFF);
    bwr(8'h0D, 32'hFFFF_FFFF);
    brd(8'h1C, d); chk("R10 hole reads zero", d, 0);
    brd(8'h40, d); chk("R10 past map reads zero", d, 0);
    brd(8'h05, d); chk("R10 unaligned reads zero", d, 0);
    brd(8'h04, d); chk("R10 out unchanged", d, 32'hA5A5_0F0F);
    brd(8'h0C, d); chk("R10 mask unchanged", d, 0);
    chk("R10 irq unchanged", 32'(irq_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_out();
    t_sync();
    t_bypass();
    t_level();
    t_edge();
    t_mask();
    t_map();
    t_share();
    t_unmapped();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule